// File: doc/BRIEF.md
# SD Data-Line Transfer Engine

This block is the data-path engine of an SD host. It carries whole blocks between 32-bit word queues and the four DAT lines of an SD card, in either 1-bit or 4-bit bus mode. A single start command supplies the transfer direction, the block size in bytes, the number of blocks (minus one) and the bus width. The engine then runs every block of the transfer by itself.

For a read, the engine waits for the card's start cycle and collects the payload. It packs the payload into 32-bit words and hands each word out with a one-cycle push strobe. It also checks an independent CRC-16 on every active lane. For a write, the engine pulls words with a one-cycle strobe, shifts them onto the lines and appends each lane's CRC-16. It drives the output enable for the frame, then reads the card's three-bit status token on DAT0 and waits while the card holds DAT0 low. A failed CRC on a read, or a rejected status on a write, stops the transfer early and clears the CRC-good flag.

The queues behind the strobes are outside this block. `tx_word` must show the head word of the transmit queue. That word is taken at the clock edge that ends a cycle with `tx_pull` high, and the queue then advances.

Top module: `sdx_data_engine`

## Requirements
- R1: While `rst` is high at a clock edge the engine returns to idle. From the next cycle `busy`, `dat_oe`, `tx_pull`, `rx_push` and `card_busy` are 0 and `dat_out` is 4'b1111. `crc_ok` is also 0 until the first command.
- R2: `cmd` = 1 starts a write and `cmd` = 2 starts a read; 0 does nothing. Size, count and width are captured at the edge that sees the command. `busy` is high from the next cycle until the cycle after the final block ends. A read block ends with its end cycle. A write block ends with the first cycle in which DAT0 is seen high after the status token.
- R3: A written frame has these cycles, in order. First one start cycle with the active lines at 0 (4'b0000 in 4-bit mode, 4'b1110 in 1-bit mode). Then the payload cycles, then 16 CRC cycles, then one end cycle at 4'b1111. `dat_oe` is 1 from the start cycle through the end cycle and 0 in the cycle after it.
- R4: With `bus_wide` = 0, only DAT0 carries data. DAT3..DAT1 are driven at 1, and on receive their values affect neither start detection nor the CRC check.
- R5: Each active lane keeps its own CRC-16 with polynomial x^16+x^12+x^5+1 (0x1021). The CRC starts at 0 and covers that lane's payload bits. It is sent on the lane most significant bit first, right after the payload.
- R6: On a write, `tx_pull` is high for one cycle in the start cycle. It is then high again in the last payload cycle of each full word that is followed by more payload, so pulls are spaced 32/width cycles apart. A block of B bytes pulls ceil(B/4) words.
- R7: Payload is sent and received most significant bit first. In 4-bit mode each cycle carries four consecutive bits, with the earliest on DAT3. On a read, `rx_push` is high for one cycle, in the cycle after the last bit of each word, with the assembled word on `rx_word`. Pushes within a block are 32/width cycles apart.
- R8: When the block size is not a multiple of 4, the last word of a block carries only its remaining bytes. On a read those bytes sit in the high-order positions and the low-order bits are 0. Exactly one strobe is still issued for that word, (remaining bytes × 8)/width cycles after the previous one.
- R9: After each written frame, the card's token on DAT0 is one start bit (0), three status bits (first received is the most significant) and one end bit. From the cycle after the end bit, `card_busy` is 1 until the cycle after DAT0 is seen high. Only then does the next block's start cycle follow.
- R10: A read block whose CRC fails on any active lane, or a written block whose status is not 3'b010, ends the transfer. No further block is started, `busy` falls and `crc_ok` is 0. When every block passes, `crc_ok` is 1 after the transfer.
- R11: `cfg_blk_last` holds the block count minus one. The engine runs that many blocks plus one, back to back, with each block's data continuing from the previous one's.
- R12: A command presented while `busy` is 1 is ignored, and the running transfer completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card-side clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | 0 none, 1 write, 2 read |
| cfg_blk_bytes | input | BSZ_W | Block size in bytes |
| cfg_blk_last | input | BCNT_W | Number of blocks minus one |
| bus_wide | input | 1 | 1 selects 4-bit mode, 0 selects 1-bit mode |
| tx_word | input | 32 | Head word of the transmit queue |
| tx_pull | output | 1 | Takes the head word from the transmit queue |
| rx_word | output | 32 | Word assembled from the card |
| rx_push | output | 1 | One-cycle strobe marking `rx_word` valid |
| dat_in | input | 4 | Sampled DAT lines |
| dat_out | output | 4 | Values driven onto the DAT lines |
| dat_oe | output | 1 | Output enable for the DAT lines |
| card_busy | output | 1 | Card is holding DAT0 low after a written block |
| busy | output | 1 | Transfer in progress |
| crc_ok | output | 1 | All blocks of the last transfer passed |

## Verification
The bench plays the card and both queues cycle by cycle, and it targets the places where the counting is easy to get wrong. Partial final words in both directions catch an engine that pushes or pulls a whole word too many, or that puts the leftover bytes at the low end. Noise on DAT3..DAT1 in 1-bit reads, and a CRC error on a single upper lane in 4-bit reads, expose an engine that checks the wrong set of lanes: it would reject good narrow blocks or accept bad wide ones. Multi-block runs with a failure on the first block or on a later one catch an engine that keeps going after an error. Commands poked in mid-transfer, and card-busy periods of zero and several cycles, catch a block that restarts, or that starts the next frame before DAT0 is released.

// File: rtl/sdx_pkg.sv
package sdx_pkg;

    localparam int WORD_W = 32;
    localparam int LANES  = 4;
    localparam int CRC_W  = 16;
    localparam logic [CRC_W-1:0] CRC_POLY    = 16'h1021;
    localparam logic [2:0]       STATUS_GOOD = 3'b010;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_READ  = 2'd2
    } cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TX_SOF,
        ST_TX_DATA,
        ST_TX_CRC,
        ST_TX_EOF,
        ST_TOK_WAIT,
        ST_TOK_BITS,
        ST_TOK_EOF,
        ST_CARD_BUSY,
        ST_RX_WAIT,
        ST_RX_DATA,
        ST_RX_CRC,
        ST_RX_EOF
    } phase_e;

    typedef enum logic [1:0] {
        LANE_HOLD,
        LANE_CLEAR,
        LANE_FEED,
        LANE_SHIFT
    } lane_op_e;

    typedef struct packed {
        logic              wide;
        logic [15:0]       bytes;
    } blk_cfg_t;

    function automatic logic [CRC_W-1:0] crc_next(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/sdx_crc_lane.sv
module sdx_crc_lane
    import sdx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  lane_op_e         op,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= '0;
        end else begin
            unique case (op)
                LANE_CLEAR: crc_q <= '0;
                LANE_FEED:  crc_q <= crc_next(crc_q, bit_in);
                LANE_SHIFT: crc_q <= {crc_q[CRC_W-2:0], 1'b0};
                default:    crc_q <= crc_q;
            endcase
        end
    end

endmodule

// File: rtl/sdx_tx_shifter.sv
module sdx_tx_shifter
    import sdx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic              wide,
    input  logic [WORD_W-1:0] load_word,
    output logic [LANES-1:0]  lane_bits
);

    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= load_word;
        end else if (shift) begin
            sh_q <= wide ? (sh_q << LANES) : (sh_q << 1);
        end
    end

    assign lane_bits = wide ? sh_q[WORD_W-1 -: LANES] : {{(LANES-1){1'b1}}, sh_q[WORD_W-1]};

endmodule

// File: rtl/sdx_rx_packer.sv
module sdx_rx_packer
    import sdx_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              flush,
    input  logic              wide,
    input  logic [SLOT_W-1:0] slot,
    input  logic [LANES-1:0]  bits,
    output logic [WORD_W-1:0] word_q,
    output logic              push_q
);

    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] ins;

    always_comb begin
        if (wide) begin
            ins = {{(WORD_W-LANES){1'b0}}, bits} << ((WORD_W - LANES) - LANES * int'(slot));
        end else begin
            ins = {{(WORD_W-1){1'b0}}, bits[0]} << ((WORD_W - 1) - int'(slot));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            word_q <= '0;
            push_q <= 1'b0;
        end else begin
            push_q <= 1'b0;
            if (take) begin
                if (flush) begin
                    word_q <= acc_q | ins;
                    push_q <= 1'b1;
                    acc_q  <= '0;
                end else begin
                    acc_q <= acc_q | ins;
                end
            end
        end
    end

    // R7
    push_single_chk: assert property (@(posedge clk) disable iff (rst) push_q |=> !push_q);

endmodule

// File: rtl/sdx_data_engine.sv
module sdx_data_engine
    import sdx_pkg::*;
#(
    parameter int BSZ_W  = 12,
    parameter int BCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd,
    input  logic [BSZ_W-1:0]  cfg_blk_bytes,
    input  logic [BCNT_W-1:0] cfg_blk_last,
    input  logic              bus_wide,
    input  logic [31:0]       tx_word,
    output logic              tx_pull,
    output logic [31:0]       rx_word,
    output logic              rx_push,
    input  logic [3:0]        dat_in,
    output logic [3:0]        dat_out,
    output logic              dat_oe,
    output logic              card_busy,
    output logic              busy,
    output logic              crc_ok
);

    localparam int CYC_W  = BSZ_W + 3;
    localparam int SLOT_W = $clog2(WORD_W);
    localparam int CNT_W  = $clog2(CRC_W);

    phase_e               state_q;
    logic [BSZ_W-1:0]     bytes_q;
    logic                 wide_q;
    logic [BCNT_W-1:0]    blk_left_q;
    logic [CYC_W-1:0]     rem_q;
    logic [SLOT_W-1:0]    slot_q;
    logic [CNT_W-1:0]     crc_cnt_q;
    logic [2:0]           tok_q;
    logic [1:0]           tok_cnt_q;
    logic                 crc_ok_q;

    logic [CYC_W-1:0]     n_cyc;
    logic [SLOT_W-1:0]    slot_last;
    logic                 last_pay;
    logic                 rx_sof;
    logic                 rx_crc_bad;
    lane_op_e             lane_op;
    logic                 lane_src_tx;
    logic [LANES-1:0]     tx_bits;
    logic [LANES-1:0]     crc_msb;
    logic [CRC_W-1:0]     lane_crc [LANES];
    logic                 shift_en;

    assign n_cyc     = wide_q ? (CYC_W'(bytes_q) << 1) : (CYC_W'(bytes_q) << 3);
    assign slot_last = wide_q ? SLOT_W'(WORD_W / LANES - 1) : SLOT_W'(WORD_W - 1);
    assign last_pay  = (rem_q == CYC_W'(1));
    assign rx_sof    = wide_q ? (dat_in == '0) : !dat_in[0];

    always_comb begin
        rx_crc_bad = (lane_crc[0] != '0);
        if (wide_q) begin
            for (int l = 1; l < LANES; l++) begin
                if (lane_crc[l] != '0) rx_crc_bad = 1'b1;
            end
        end
    end

    // Per-lane CRC engines
    always_comb begin
        unique case (state_q)
            ST_TX_SOF, ST_RX_WAIT:              lane_op = LANE_CLEAR;
            ST_TX_DATA, ST_RX_DATA, ST_RX_CRC:  lane_op = LANE_FEED;
            ST_TX_CRC:                          lane_op = LANE_SHIFT;
            default:                            lane_op = LANE_HOLD;
        endcase
    end

    assign lane_src_tx = (state_q == ST_TX_DATA);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sdx_crc_lane u_crc (
            .clk    (clk),
            .rst    (rst),
            .op     (lane_op),
            .bit_in (lane_src_tx ? tx_bits[g] : dat_in[g]),
            .crc_q  (lane_crc[g])
        );
        assign crc_msb[g] = lane_crc[g][CRC_W-1];
    end

    // Transmit word path
    assign tx_pull  = (state_q == ST_TX_SOF) ||
                      (state_q == ST_TX_DATA && slot_q == slot_last && !last_pay);
    assign shift_en = (state_q == ST_TX_DATA);

    sdx_tx_shifter u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (tx_pull),
        .shift     (shift_en),
        .wide      (wide_q),
        .load_word (tx_word),
        .lane_bits (tx_bits)
    );

    // Receive word path
    sdx_rx_packer #(.SLOT_W(SLOT_W)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .take   (state_q == ST_RX_DATA),
        .flush  (slot_q == slot_last || last_pay),
        .wide   (wide_q),
        .slot   (slot_q),
        .bits   (dat_in),
        .word_q (rx_word),
        .push_q (rx_push)
    );

    // Line drive
    always_comb begin
        dat_oe  = 1'b1;
        dat_out = '1;
        unique case (state_q)
            ST_TX_SOF:  dat_out = wide_q ? '0 : {{(LANES-1){1'b1}}, 1'b0};
            ST_TX_DATA: dat_out = tx_bits;
            ST_TX_CRC:  dat_out = wide_q ? crc_msb : {{(LANES-1){1'b1}}, crc_msb[0]};
            ST_TX_EOF:  dat_out = '1;
            default:    dat_oe  = 1'b0;
        endcase
    end

    assign card_busy = (state_q == ST_CARD_BUSY);
    assign busy      = (state_q != ST_IDLE);
    assign crc_ok    = crc_ok_q;

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            bytes_q    <= '0;
            wide_q     <= 1'b0;
            blk_left_q <= '0;
            rem_q      <= '0;
            slot_q     <= '0;
            crc_cnt_q  <= '0;
            tok_q      <= '0;
            tok_cnt_q  <= '0;
            crc_ok_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd == CMD_WRITE || cmd == CMD_READ) begin
                        bytes_q    <= cfg_blk_bytes;
                        wide_q     <= bus_wide;
                        blk_left_q <= cfg_blk_last;
                        crc_ok_q   <= 1'b1;
                        state_q    <= (cmd == CMD_WRITE) ? ST_TX_SOF : ST_RX_WAIT;
                    end
                end
                ST_TX_SOF: begin
                    rem_q   <= n_cyc;
                    slot_q  <= '0;
                    state_q <= ST_TX_DATA;
                end
                ST_TX_DATA, ST_RX_DATA: begin
                    rem_q  <= rem_q - CYC_W'(1);
                    slot_q <= (slot_q == slot_last) ? '0 : slot_q + SLOT_W'(1);
                    if (last_pay) begin
                        crc_cnt_q <= '0;
                        state_q   <= (state_q == ST_TX_DATA) ? ST_TX_CRC : ST_RX_CRC;
                    end
                end
                ST_TX_CRC, ST_RX_CRC: begin
                    crc_cnt_q <= crc_cnt_q + CNT_W'(1);
                    if (crc_cnt_q == CNT_W'(CRC_W - 1)) begin
                        state_q <= (state_q == ST_TX_CRC) ? ST_TX_EOF : ST_RX_EOF;
                    end
                end
                ST_TX_EOF: state_q <= ST_TOK_WAIT;
                ST_TOK_WAIT: begin
                    if (!dat_in[0]) begin
                        tok_cnt_q <= '0;
                        state_q   <= ST_TOK_BITS;
                    end
                end
                ST_TOK_BITS: begin
                    tok_q     <= {tok_q[1:0], dat_in[0]};
                    tok_cnt_q <= tok_cnt_q + 2'd1;
                    if (tok_cnt_q == 2'd2) state_q <= ST_TOK_EOF;
                end
                ST_TOK_EOF: state_q <= ST_CARD_BUSY;
                ST_CARD_BUSY: begin
                    if (dat_in[0]) begin
                        if (tok_q != STATUS_GOOD) begin
                            crc_ok_q <= 1'b0;
                            state_q  <= ST_IDLE;
                        end else if (blk_left_q == '0) begin
                            state_q <= ST_IDLE;
                        end else begin
                            blk_left_q <= blk_left_q - BCNT_W'(1);
                            state_q    <= ST_TX_SOF;
                        end
                    end
                end
                ST_RX_WAIT: begin
                    rem_q  <= n_cyc;
                    slot_q <= '0;
                    if (rx_sof) state_q <= ST_RX_DATA;
                end
                ST_RX_EOF: begin
                    if (rx_crc_bad) begin
                        crc_ok_q <= 1'b0;
                        state_q  <= ST_IDLE;
                    end else if (blk_left_q == '0) begin
                        state_q <= ST_IDLE;
                    end else begin
                        blk_left_q <= blk_left_q - BCNT_W'(1);
                        state_q    <= ST_RX_WAIT;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!dat_oe && dat_out == 4'hF && !tx_pull && !rx_push));

    // R4
    narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
        !wide_q |-> (dat_out[3:1] == 3'b111));

    // R6
    pull_single_chk: assert property (@(posedge clk) disable iff (rst) tx_pull |=> !tx_pull);

    // R9
    card_busy_quiet_chk: assert property (@(posedge clk) disable iff (rst) card_busy |-> !dat_oe);

    // R3
    oe_after_end_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TX_EOF) |=> !dat_oe);

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) !(tx_pull && rx_push));

endmodule

// File: tb/sdx_data_engine_tb.sv
`timescale 1ns/1ps
module sdx_data_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cmd = 2'd0;
    logic [11:0] cfg_blk_bytes = '0;
    logic [7:0]  cfg_blk_last = '0;
    logic        bus_wide = 1'b0;
    logic [31:0] tx_word;
    logic        tx_pull;
    logic [31:0] rx_word;
    logic        rx_push;
    logic [3:0]  dat_in = 4'hF;
    logic [3:0]  dat_out;
    logic        dat_oe;
    logic        card_busy;
    logic        busy;
    logic        crc_ok;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int tx_k = 0;
    int push_n = 0;
    logic [31:0] push_log [64];
    int          push_cyc [64];

    always #10 clk = ~clk;

    sdx_data_engine u_dut (
        .clk(clk), .rst(rst), .cmd(cmd), .cfg_blk_bytes(cfg_blk_bytes),
        .cfg_blk_last(cfg_blk_last), .bus_wide(bus_wide), .tx_word(tx_word),
        .tx_pull(tx_pull), .rx_word(rx_word), .rx_push(rx_push), .dat_in(dat_in),
        .dat_out(dat_out), .dat_oe(dat_oe), .card_busy(card_busy), .busy(busy),
        .crc_ok(crc_ok)
    );

    function automatic logic [31:0] tw(int j);
        return (32'(j) * 32'h9E3779B1) ^ 32'h5A5A1234;
    endfunction

    function automatic logic [7:0] rb(int g);
        return 8'((g * 29 + 7) ^ (g >> 2));
    endfunction

    function automatic logic [15:0] bcrc(logic [15:0] c, logic b);
        logic fb;
        fb = c[15] ^ b;
        c = c << 1;
        if (fb) c = c ^ 16'h1021;
        return c;
    endfunction

    assign tx_word = tw(tx_k);
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (tx_pull) tx_k <= tx_k + 1;
    end

    always @(negedge clk) begin
        if (rx_push && push_n < 64) begin
            push_log[push_n] = rx_word;
            push_cyc[push_n] = cyc;
            push_n = push_n + 1;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "dat_oe", 32'(dat_oe), 0);
        chk("R1", "dat_out", 32'(dat_out), 32'hF);
        chk("R1", "strobes", {30'b0, tx_pull, rx_push}, 0);
        chk("R1", "card_busy/crc_ok", {30'b0, card_busy, crc_ok}, 0);
    endtask

    // Card model receiving a write; bad status on block 0 when bad_stat.
    task automatic do_write(int bytes, int nblk, bit wide, int bsy, bit bad_stat, bit poke);
        int w, n, nw, base, k0, done;
        logic [15:0] lc [4];
        logic [3:0] exp;
        logic [2:0] st;
        w = wide ? 4 : 1;
        n = bytes * 8 / w;
        nw = (bytes + 3) / 4;
        k0 = tx_k;
        done = 0;
        @(negedge clk);
        cmd = 2'd1; cfg_blk_bytes = 12'(bytes); cfg_blk_last = 8'(nblk - 1); bus_wide = wide;
        @(negedge clk);
        cmd = 2'd0; cfg_blk_bytes = '0; cfg_blk_last = '0; bus_wide = 1'b0;
        for (int b = 0; b < nblk; b++) begin
            base = tx_k;
            chk("R2", "busy at frame start", 32'(busy), 1);
            chk("R3", "start cycle lines", {27'b0, dat_oe, dat_out}, {27'b0, 1'b1, (wide ? 4'h0 : 4'hE)});
            chk("R6", "pull in start cycle", 32'(tx_pull), 1);
            for (int l = 0; l < 4; l++) lc[l] = '0;
            for (int i = 0; i < n; i++) begin
                @(negedge clk);
                cmd = (poke && b == 0 && i == 2) ? 2'd2 : 2'd0;
                for (int l = 0; l < 4; l++) begin
                    int p;
                    if (wide) p = i * 4 + (3 - l); else p = i;
                    if (!wide && l > 0) exp[l] = 1'b1;
                    else begin
                        exp[l] = tw(base + p / 32)[31 - (p % 32)];
                        lc[l] = bcrc(lc[l], exp[l]);
                    end
                end
                chk(wide ? "R7" : "R4", "payload lines", {27'b0, dat_oe, dat_out}, {27'b0, 1'b1, exp});
                chk("R6", "pull timing", 32'(tx_pull),
                    32'(((i + 1) % (32 / w) == 0) && (i != n - 1)));
            end
            cmd = 2'd0;
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                for (int l = 0; l < 4; l++) exp[l] = (!wide && l > 0) ? 1'b1 : lc[l][15 - c];
                chk("R5", "crc lines", {27'b0, dat_oe, dat_out}, {27'b0, 1'b1, exp});
            end
            @(negedge clk);
            chk("R3", "end cycle", {27'b0, dat_oe, dat_out}, {27'b0, 5'h1F});
            @(negedge clk);
            chk("R3", "oe low after end", 32'(dat_oe), 0);
            chk((bytes % 4 != 0) ? "R8" : "R6", "words pulled", 32'(tx_k - base), 32'(nw));
            st = (bad_stat && b == 0) ? 3'b101 : 3'b010;
            dat_in = 4'hE;
            @(negedge clk);
            for (int s = 2; s >= 0; s--) begin
                dat_in = {3'b111, st[s]};
                @(negedge clk);
            end
            dat_in = 4'hF;
            @(negedge clk);
            for (int j = 0; j <= bsy; j++) begin
                chk("R9", "card_busy held", 32'(card_busy), 1);
                chk("R9", "no frame while busy", 32'(dat_oe), 0);
                dat_in = (j < bsy) ? 4'hE : 4'hF;
                @(negedge clk);
            end
            chk("R9", "card_busy released", 32'(card_busy), 0);
            done++;
            if (bad_stat && b == 0) begin
                chk("R10", "busy after bad status", 32'(busy), 0);
                chk("R10", "crc_ok after bad status", 32'(crc_ok), 0);
                break;
            end
            if (b == nblk - 1) begin
                chk("R2", "busy after last block", 32'(busy), 0);
                chk("R10", "crc_ok after good write", 32'(crc_ok), 1);
            end
        end
        repeat (6) begin
            @(negedge clk);
            chk("R11", "no extra frame", {30'b0, dat_oe, busy}, 0);
        end
        chk("R11", "total words pulled", 32'(tx_k - k0), 32'(nw * done));
    endtask

    // Card model sending a read; bad_blk < 0 means no corruption.
    task automatic do_read(int bytes, int nblk, bit wide, int bad_blk, int bad_lane, bit poke);
        int w, n, nw, pbase, done, rem_b;
        logic [15:0] lc [4];
        logic [3:0] v;
        logic [31:0] ew;
        w = wide ? 4 : 1;
        n = bytes * 8 / w;
        nw = (bytes + 3) / 4;
        done = 0;
        pbase = push_n;
        @(negedge clk);
        cmd = 2'd2; cfg_blk_bytes = 12'(bytes); cfg_blk_last = 8'(nblk - 1); bus_wide = wide;
        @(negedge clk);
        cmd = 2'd0; cfg_blk_bytes = '0; cfg_blk_last = '0; bus_wide = 1'b0;
        chk("R2", "busy after read command", 32'(busy), 1);
        chk("R2", "no drive during read", 32'(dat_oe), 0);
        for (int b = 0; b < nblk; b++) begin
            for (int i = 0; i < 2; i++) begin
                dat_in = wide ? 4'hF : {3'(i * 3 + b), 1'b1};
                @(negedge clk);
            end
            dat_in = wide ? 4'h0 : {3'(b + 5), 1'b0};
            @(negedge clk);
            for (int l = 0; l < 4; l++) lc[l] = '0;
            for (int i = 0; i < n; i++) begin
                for (int l = 0; l < 4; l++) begin
                    int p;
                    if (wide) p = i * 4 + (3 - l); else p = i;
                    if (!wide && l > 0) v[l] = 1'(i * 3 + l);
                    else begin
                        v[l] = rb(b * bytes + p / 8)[7 - (p % 8)];
                        lc[l] = bcrc(lc[l], v[l]);
                    end
                end
                dat_in = v;
                cmd = (poke && b == 0 && i == 3) ? 2'd1 : 2'd0;
                @(negedge clk);
            end
            cmd = 2'd0;
            for (int c = 0; c < 16; c++) begin
                for (int l = 0; l < 4; l++) begin
                    if (!wide && l > 0) v[l] = 1'(c + l);
                    else v[l] = lc[l][15 - c] ^ ((b == bad_blk && l == bad_lane && c == 5) ? 1'b1 : 1'b0);
                end
                dat_in = v;
                @(negedge clk);
            end
            dat_in = 4'hF;
            @(negedge clk);
            done++;
            if (b == bad_blk) begin
                chk("R10", "busy after crc error", 32'(busy), 0);
                chk("R10", "crc_ok after crc error", 32'(crc_ok), 0);
                break;
            end
            chk("R2", "busy after read block", 32'(busy), (b == nblk - 1) ? 0 : 1);
            if (b == nblk - 1) chk(wide ? "R5" : "R4", "crc_ok after good read", 32'(crc_ok), 1);
        end
        repeat (4) @(negedge clk);
        chk("R11", "idle after read", 32'(busy), 0);
        chk("R7", "push count", 32'(push_n - pbase), 32'(done * nw));
        rem_b = bytes - 4 * (nw - 1);
        for (int b = 0; b < done; b++) begin
            for (int j = 0; j < nw; j++) begin
                int idx;
                idx = pbase + b * nw + j;
                ew = '0;
                for (int k = 0; k < 4; k++)
                    if (4 * j + k < bytes) ew[31 - 8 * k -: 8] = rb(b * bytes + 4 * j + k);
                if (idx < push_n) begin
                    chk((4 * j + 4 > bytes) ? "R8" : "R7", "pushed word", push_log[idx], ew);
                    if (j > 0)
                        chk((j == nw - 1 && rem_b != 4) ? "R8" : "R7", "push spacing",
                            32'(push_cyc[idx] - push_cyc[idx - 1]),
                            32'((j == nw - 1) ? rem_b * 8 / w : 32 / w));
                end
            end
        end
        dat_in = 4'hF;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        do_write(8, 1, 1'b0, 3, 1'b0, 1'b0);    // R3 R4 R5 R6 R9
        do_write(10, 2, 1'b1, 0, 1'b0, 1'b1);   // R8 R11 R12 in 4-bit mode
        do_read(8, 1, 1'b0, -1, 0, 1'b0);       // R4 R7 with noise on upper lanes
        do_read(6, 3, 1'b1, -1, 0, 1'b1);       // R8 R11 R12
        do_read(8, 2, 1'b1, 0, 2, 1'b0);        // R10 error on upper lane
        do_read(4, 2, 1'b0, 1, 0, 1'b0);        // R10 error on a later block
        do_write(8, 3, 1'b1, 2, 1'b1, 1'b0);    // R10 bad status
        do_write(5, 1, 1'b0, 1, 1'b0, 1'b0);    // R8 partial narrow write
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule